// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked system use an external 8192-word by 8-bit asynchronous static RAM. The user side is a request/acknowledge handshake. The user holds `req_valid` together with an address, a direction flag and write data until the controller returns a one-cycle `ack`. For a read, the captured byte is valid on `rd_data` in that same `ack` cycle.

On the memory side the controller drives the address and four strobes from registers. These are a select that is active low, a select that is active high, a write strobe and an output enable. The bidirectional data bus is split into a driven value, a driver enable and a sampled input. Each phase of an access lasts a whole number of clock cycles, set by parameters, so one netlist can meet any speed grade at any clock period. Writes are timed by the write strobe. The output enable stays high for the whole write. The address and data stay fixed while the strobe is low. When a read follows a write, one dead cycle is added so the two drivers never share the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `mem_ce_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `ack`=0.
- R2: A write selects the memory (`mem_ce_n`=0, `mem_ce2`=1) with `mem_we_n` high for SETUP_CYC cycles. It then holds `mem_we_n` low for exactly PULSE_CYC cycles, followed by HOLD_CYC selected cycles with `mem_we_n` high. The byte is then stored at the requested address.
- R3: While `mem_we_n` is low, `mem_addr` and `mem_dq_out` do not change.
- R4: Throughout a write strobe, `mem_oe_n` is 1, `mem_dq_oe` is 1 and the memory is selected.
- R5: A read selects the memory with `mem_oe_n`=0 and `mem_dq_oe`=0 for ACCESS_CYC cycles. At the end of the last of those cycles it registers `mem_dq_in` into `rd_data`.
- R6: `ack` is high for exactly one cycle per request. Counting clock edges from the first edge that sees the request, `ack` appears after 1+SETUP_CYC+PULSE_CYC+HOLD_CYC edges for a write and 1+ACCESS_CYC edges for a read.
- R7: A read whose previous access was a write is delayed by one extra idle cycle, giving a latency of 2+ACCESS_CYC edges. `mem_dq_oe` and a low `mem_oe_n` are never active together.
- R8: In the `ack` cycle and between accesses, the memory is deselected, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R9: A `req_valid` still high at the edge that ends the `ack` cycle does not start a new access.
- R10: `rd_data` changes only when a read is acknowledged; a write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Byte to write |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| mem_addr | output | 13 | Memory address lines |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_ce2 | output | 1 | Memory select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Controller data driver enable |
| mem_dq_in | input | 8 | Value sampled from the data bus |

## Verification
Two functions can fall on the same cycle. The end of one access (its acknowledge and the bus release) can coincide with a request still being presented, and the end of a write can coincide with a read that wants to turn the bus around. The bench provokes the first by holding the request high past the acknowledge edge. It then checks that no select or acknowledge follows. It provokes the second by issuing reads directly after writes, in directed pairs and in a seeded random mix. There it checks the one-cycle-longer latency, the absence of any cycle with both drivers enabled, and the byte read back from a memory model that latches data at the end of the write strobe.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC
  } seq_state_t;

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 2,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 2,
  parameter int CNT_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  input  logic              tmr_expired
);

  localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD  = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] ACCESS_LD = CNT_W'(ACCESS_CYC - 1);

  seq_state_t state_q;
  logic       wr_last_q;
  logic       go;
  logic       start;

  // A request is taken only when it is not the one just acknowledged,
  // and a read right after a write first spends one dead cycle.
  assign go    = req_valid && !ack;
  assign start = go && (req_write || !wr_last_q);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          tmr_load = 1'b1;
          tmr_val  = req_write ? SETUP_LD : ACCESS_LD;
        end
      end
      ST_WSETUP: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          tmr_val  = PULSE_LD;
        end
      end
      ST_WPULSE: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          tmr_val  = HOLD_LD;
        end
      end
      default: begin
        tmr_load = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      wr_last_q  <= 1'b0;
      ack        <= 1'b0;
      rd_data    <= '0;
      mem_addr   <= '0;
      mem_ce_n   <= 1'b1;
      mem_ce2    <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      ack <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (go && !req_write && wr_last_q) begin
            wr_last_q <= 1'b0;
          end else if (start) begin
            mem_addr <= req_addr;
            mem_ce_n <= 1'b0;
            mem_ce2  <= 1'b1;
            mem_we_n <= 1'b1;
            if (req_write) begin
              mem_dq_out <= req_wdata;
              mem_dq_oe  <= 1'b1;
              mem_oe_n   <= 1'b1;
              state_q    <= ST_WSETUP;
            end else begin
              mem_dq_oe <= 1'b0;
              mem_oe_n  <= 1'b0;
              state_q   <= ST_RACC;
            end
          end
        end
        ST_WSETUP: begin
          if (tmr_expired) begin
            mem_we_n <= 1'b0;
            state_q  <= ST_WPULSE;
          end
        end
        ST_WPULSE: begin
          if (tmr_expired) begin
            mem_we_n <= 1'b1;
            state_q  <= ST_WHOLD;
          end
        end
        ST_WHOLD: begin
          if (tmr_expired) begin
            mem_ce_n  <= 1'b1;
            mem_ce2   <= 1'b0;
            mem_dq_oe <= 1'b0;
            ack       <= 1'b1;
            wr_last_q <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        ST_RACC: begin
          if (tmr_expired) begin
            rd_data   <= mem_dq_in;
            mem_ce_n  <= 1'b1;
            mem_ce2   <= 1'b0;
            mem_oe_n  <= 1'b1;
            ack       <= 1'b1;
            wr_last_q <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: strobe only falls on a part that was already selected
  assert_sel_before_we_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(!mem_ce_n && mem_ce2));

  // R3: address and data frozen across the strobe
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dq_out)));

  // R4: output enable off and own driver on during the strobe
  assert_oe_high_in_write_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n && mem_ce2));

  // R6: single-cycle acknowledge
  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R7: both drivers never enabled together
  assert_no_bus_fight_R7: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n));

  // R8: quiet bus whenever the sequencer waits
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R10: read data moves only with an acknowledge
  assert_rd_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data) |-> ack);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 2,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int CNT_MAX = max_of3(SETUP_CYC + HOLD_CYC, PULSE_CYC, ACCESS_CYC);
  localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  sram_phase_timer #(
    .CNT_W (CNT_W)
  ) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_ctrl_seq #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SETUP_CYC  (SETUP_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .ACCESS_CYC (ACCESS_CYC),
    .CNT_W      (CNT_W)
  ) seq_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .ack         (ack),
    .rd_data     (rd_data),
    .mem_addr    (mem_addr),
    .mem_ce_n    (mem_ce_n),
    .mem_ce2     (mem_ce2),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_dq_out  (mem_dq_out),
    .mem_dq_oe   (mem_dq_oe),
    .mem_dq_in   (mem_dq_in),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .tmr_expired (tmr_expired)
  );

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam int SETUP = 2;
  localparam int PULSE = 3;
  localparam int HOLD  = 1;
  localparam int ACCESS = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          ack;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_async_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE),
    .HOLD_CYC(HOLD), .ACCESS_CYC(ACCESS)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory model: latches data at the end of the write overlap
  logic [DW-1:0] model_mem [int unsigned];
  logic [DW-1:0] ref_mem   [int unsigned];
  bit            wr_prev = 1'b0;
  int unsigned   wr_addr_last = 0;
  logic [DW-1:0] wr_data_last = '0;
  bit            pulse_on = 1'b0;
  int            pulse_len = 0;
  int            pre_len = 0;
  logic [AW-1:0] snap_addr = '0;
  logic [DW-1:0] snap_data = '0;

  always @(negedge clk) begin
    bit sel;
    bit wr_now;
    sel = !mem_ce_n && mem_ce2;
    wr_now = sel && !mem_we_n;
    if (!rst) begin
      if (wr_prev && !wr_now) model_mem[wr_addr_last] = wr_data_last;
      if (wr_now) begin
        wr_addr_last = int'(mem_addr);
        wr_data_last = mem_dq_out;
      end
      if (sel && mem_we_n && !mem_oe_n)
        mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : '0;
      else
        mem_dq_in = '0;
      // R7: never both drivers
      if (mem_dq_oe && !mem_oe_n) chk(1'b0, "R7 bus fight", 1, 0);
      if (!mem_we_n) begin
        if (!pulse_on) begin
          chk(pre_len == SETUP, "R2 setup cycles", pre_len, SETUP);
          snap_addr = mem_addr;
          snap_data = mem_dq_out;
          pulse_len = 0;
        end
        pulse_on = 1'b1;
        pulse_len++;
        if (mem_addr != snap_addr) chk(1'b0, "R3 addr moved", int'(mem_addr), int'(snap_addr));
        if (mem_dq_out != snap_data) chk(1'b0, "R3 data moved", int'(mem_dq_out), int'(snap_data));
        if (!(mem_oe_n && mem_dq_oe && sel)) chk(1'b0, "R4 strobe state", int'({mem_oe_n, mem_dq_oe, sel}), 7);
      end else begin
        if (pulse_on) chk(pulse_len == PULSE, "R2 pulse cycles", pulse_len, PULSE);
        pulse_on = 1'b0;
        if (sel) pre_len++; else pre_len = 0;
      end
    end
    wr_prev = wr_now;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  bit            prev_write = 1'b0;
  logic [DW-1:0] last_rd = '0;

  function automatic int exp_latency(input bit wr, input bit pw);
    if (wr) return 1 + SETUP + PULSE + HOLD;
    return (pw ? 2 : 1) + ACCESS;
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
  endfunction

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit late);
    int lat;
    int want;
    want = exp_latency(wr, prev_write);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!ack && lat < 60);
    if (wr) chk(lat == want, "R6 write latency", lat, want);
    else chk(lat == want, prev_write ? "R7 read-after-write latency" : "R6 read latency", lat, want);
    chk(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe, "R8 quiet at ack",
        int'({mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}), 5'b10110);
    if (wr) begin
      ref_mem[int'(a)] = d;
      chk(rd_data == last_rd, "R10 rd_data kept on write", int'(rd_data), int'(last_rd));
    end else begin
      chk(rd_data == exp_read(a), "R5 read data", int'(rd_data), int'(exp_read(a)));
      last_rd = rd_data;
    end
    if (!late) req_valid = 1'b0;
    @(negedge clk);
    chk(!ack, "R6 ack single cycle", int'(ack), 0);
    if (late) begin
      chk(mem_ce_n && !mem_ce2, "R9 held request not restarted", int'(mem_ce_n), 1);
      req_valid = 1'b0;
    end
    prev_write = wr;
  endtask

  initial begin
    int unsigned seed_init;
    logic [AW-1:0] pool [8];
    seed_init = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    chk(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && !ack, "R1 reset pins",
        int'({mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, ack}), 6'b101100);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && !ack, "R1 after release",
        int'({mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, ack}), 6'b101100);
    chk(rd_data == '0, "R1 rd_data cleared", int'(rd_data), 0);

    // directed corners
    do_op(1'b0, 13'h0005, 8'h00, 1'b0);        // R5 read of unwritten word
    do_op(1'b1, 13'h0000, 8'hA5, 1'b0);        // R2 lowest address
    do_op(1'b1, 13'h1FFF, 8'h3C, 1'b0);        // R2 highest address
    do_op(1'b0, 13'h0000, 8'h00, 1'b0);        // R7 read right after write
    do_op(1'b0, 13'h1FFF, 8'h00, 1'b0);        // R6 read after read
    do_op(1'b1, 13'h0ABC, 8'hFF, 1'b1);        // R9 request held past ack
    do_op(1'b0, 13'h0ABC, 8'h00, 1'b1);        // R9 on a read
    do_op(1'b1, 13'h0ABC, 8'h00, 1'b0);        // R10 write keeps rd_data
    do_op(1'b0, 13'h0ABC, 8'h00, 1'b0);

    foreach (pool[k]) pool[k] = AW'($urandom);
    pool[0] = '0;
    pool[1] = '1;
    for (int i = 0; i < 400; i++) begin
      bit wr;
      logic [AW-1:0] a;
      wr = ($urandom % 2) == 0;
      a = (($urandom % 4) != 0) ? pool[$urandom % 8] : AW'($urandom);
      do_op(wr, a, DW'($urandom), ($urandom % 8) == 0);
      if (($urandom % 4) == 0) repeat ($urandom % 3) @(negedge clk);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule